// File: doc/BRIEF.md
# RTC Interrupt Flag and Enable Unit

This unit holds the interrupt status and control for a PC-style real-time clock. The timekeeping logic sends three single-cycle event pulses into it: periodic tick, alarm match and update-ended. Each pulse sets a sticky flag. A matching enable bit decides whether that flag counts toward the interrupt request. Flags latch whether or not their enable is set. Only enabled flags drive the summary bit and the `irq` output.

Software reaches the unit through a byte-wide register port with a 2-bit address:

| Address | Register | Behaviour |
|---|---|---|
| 0 | Flag register | Read-only. A read returns the flags and then clears them. |
| 1 | Control register | Read/write. A write replaces all three enables. |
| 2 | Enable-set port | Write-only. Each written 1 sets the matching enable. |
| 3 | Enable-clear port | Write-only. Each written 1 clears the matching enable. |

Reads of address 2 or 3 return the control value.

Each source uses the same bit position in every register, so one mask selects both a flag and its enable. Read data is registered and appears the cycle after `rd_en`.

Top module: `rtc_irq_unit`

## Requirements
- R1: After reset, all flags and all enables are zero, `irq` is low and `rdata` is 0x00.
- R2: A pulse on `evt_periodic`, `evt_alarm` or `evt_update` sets its flag at bit 6, bit 5 or bit 4 respectively. This happens whatever the state of the matching enable.
- R3: A flag-register read (address 0) returns the latched flags in bits 6..4 and zeros in bits 3..0. The data is valid on `rdata` from the edge that samples `rd_en`.
- R4: Bit 7 of a flag-register read is 1 only when at least one flag is set together with its enable (enables at bits 6..4 of the control register).
- R5: `irq` is high while any flag is set together with its enable. It rises in the cycle after the edge that latches an enabled event.
- R6: A flag-register read clears all flags at the same edge, so `irq` is low in the following cycle unless a new enabled event arrived with the read.
- R7: An event pulse in the same cycle as a flag-register read is not part of that read. It stays latched and appears in the next read.
- R8: A write to address 1 loads the enables from bits 6..4 of `wdata` and ignores the other bits. Reading address 1 returns the enables at bits 6..4 and zeros elsewhere.
- R9: A write to address 2 sets each enable whose bit of `wdata` is 1. A write to address 3 clears each enable whose bit of `wdata` is 1. Enables written as 0 keep their value.
- R10: Setting an enable while its flag is already latched raises `irq` in the cycle after the write.
- R11: A write to address 0 leaves the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 2 | Register address |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Registered read data |
| evt_periodic | input | 1 | Periodic tick pulse |
| evt_alarm | input | 1 | Alarm match pulse |
| evt_update | input | 1 | Update-ended pulse |
| irq | output | 1 | Active-high interrupt request |

## Verification
A flag that fails to latch, or one that is not cleared, shows at the next flag-register read: the bit itself is wrong, and so is the summary bit. When the flag is enabled, `irq` shows the fault one cycle after the event or after the read. A corrupted enable changes `irq` in the cycle after the write. It also shows on an immediate read of the control register.

// File: rtl/rtc_irq_unit.sv
module rtc_irq_unit #(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rdata,
  input  logic              evt_periodic,
  input  logic              evt_alarm,
  input  logic              evt_update,
  output logic              irq
);
  localparam int NSRC   = 3;
  localparam int SUM_B  = DATA_W - 1;
  localparam int SRC_HI = SUM_B - 1;
  localparam int SRC_LO = SUM_B - NSRC;
  localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(3);

  logic [NSRC-1:0] flag_q, en_q, evt, hit;
  logic            flag_rd;
  logic [NSRC-1:0] wsrc;

  assign evt     = {evt_periodic, evt_alarm, evt_update};
  assign wsrc    = wdata[SRC_HI:SRC_LO];
  assign hit     = flag_q & en_q;
  assign flag_rd = rd_en && (addr == A_FLAG);
  assign irq     = |hit;

  always_ff @(posedge clk) begin
    if (!rst_n) flag_q <= '0;
    else if (flag_rd) flag_q <= evt;
    else flag_q <= flag_q | evt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) en_q <= '0;
    else if (wr_en) begin
      unique case (addr)
        A_CTRL:  en_q <= wsrc;
        A_SET:   en_q <= en_q | wsrc;
        A_CLR:   en_q <= en_q & ~wsrc;
        default: en_q <= en_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= '0;
    else if (rd_en) begin
      rdata <= '0;
      if (flag_rd) begin
        rdata[SUM_B]         <= |hit;
        rdata[SRC_HI:SRC_LO] <= flag_q;
      end else begin
        rdata[SRC_HI:SRC_LO] <= en_q;
      end
    end
  end
endmodule

module rtc_irq_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] addr,
  input logic       wr_en,
  input logic [7:0] wdata,
  input logic       rd_en,
  input logic [7:0] rdata,
  input logic       evt_periodic,
  input logic       evt_alarm,
  input logic       evt_update,
  input logic       irq,
  input logic [2:0] flag_q,
  input logic [2:0] en_q
);
  logic frd;
  assign frd = rd_en && addr == 2'd0;

  AST_PERIODIC_LATCH: assert property (@(posedge clk) disable iff (!rst_n) evt_periodic |=> flag_q[2]); // R2
  AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n) frd |=> rdata[3:0] == 4'h0); // R3
  AST_SUMMARY_GATED: assert property (@(posedge clk) disable iff (!rst_n) frd |=> (rdata[7] == |(rdata[6:4] & $past(en_q)))); // R4
  AST_READ_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n) (frd && !evt_periodic && !evt_alarm && !evt_update) |=> !irq); // R6
  AST_NO_EVENT_LOSS: assert property (@(posedge clk) disable iff (!rst_n) (frd && evt_alarm) |=> flag_q[1]); // R7
  AST_SET_PORT: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && addr == 2'd2 && wdata[5]) |=> en_q[1]); // R9
  AST_FLAG_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && !rd_en && addr == 2'd0) |=> ((flag_q & $past(flag_q)) == $past(flag_q))); // R11
endmodule

bind rtc_irq_unit rtc_irq_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
  .rd_en(rd_en), .rdata(rdata), .evt_periodic(evt_periodic),
  .evt_alarm(evt_alarm), .evt_update(evt_update), .irq(irq),
  .flag_q(flag_q), .en_q(en_q)
);

// File: tb/tb_rtc_irq_unit.sv
module tb_rtc_irq_unit;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [1:0] addr = 0;
  logic       wr_en = 0, rd_en = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic       evt_periodic = 0, evt_alarm = 0, evt_update = 0;
  logic       irq;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  rtc_irq_unit dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .rd_en(rd_en), .rdata(rdata), .evt_periodic(evt_periodic),
    .evt_alarm(evt_alarm), .evt_update(evt_update), .irq(irq)
  );

  // {op[1:0] (0 idle,1 write,2 read), addr[1:0], wdata[7:0], evt{p,a,u}, exp_rdata[7:0], exp_irq}
  localparam int NV = 23;
  localparam logic [23:0] VEC [NV] = '{
    {2'd0, 2'd0, 8'h00, 3'b100, 8'h00, 1'b0}, // R2 periodic latches while disabled
    {2'd2, 2'd0, 8'h00, 3'b000, 8'h40, 1'b0}, // R3 R4 no summary
    {2'd1, 2'd1, 8'hFF, 3'b000, 8'h00, 1'b0}, // R8
    {2'd2, 2'd1, 8'h00, 3'b000, 8'h70, 1'b0}, // R8 readback
    {2'd0, 2'd0, 8'h00, 3'b010, 8'h00, 1'b1}, // R5
    {2'd2, 2'd0, 8'h00, 3'b000, 8'hA0, 1'b0}, // R4 R6
    {2'd1, 2'd3, 8'h40, 3'b000, 8'h00, 1'b0}, // R9 clear
    {2'd0, 2'd0, 8'h00, 3'b100, 8'h00, 1'b0}, // R2 R5 gated
    {2'd2, 2'd0, 8'h00, 3'b000, 8'h40, 1'b0}, // R4
    {2'd0, 2'd0, 8'h00, 3'b001, 8'h00, 1'b1}, // R5 update
    {2'd2, 2'd0, 8'h00, 3'b100, 8'h90, 1'b0}, // R7 event with read
    {2'd2, 2'd0, 8'h00, 3'b000, 8'h40, 1'b0}, // R7 kept
    {2'd0, 2'd0, 8'h00, 3'b100, 8'h00, 1'b0},
    {2'd1, 2'd2, 8'h40, 3'b000, 8'h00, 1'b1}, // R9 R10
    {2'd1, 2'd0, 8'h00, 3'b000, 8'h00, 1'b1}, // R11
    {2'd2, 2'd0, 8'h00, 3'b000, 8'hC0, 1'b0}, // R11 flag survived
    {2'd1, 2'd1, 8'h0F, 3'b000, 8'h00, 1'b0}, // R8 low bits ignored
    {2'd2, 2'd1, 8'h00, 3'b000, 8'h00, 1'b0}, // R8
    {2'd0, 2'd0, 8'h00, 3'b111, 8'h00, 1'b0}, // R2 all disabled
    {2'd2, 2'd0, 8'h00, 3'b000, 8'h70, 1'b0}, // R3
    {2'd1, 2'd1, 8'h70, 3'b000, 8'h00, 1'b0},
    {2'd2, 2'd0, 8'h00, 3'b010, 8'h00, 1'b1}, // R7 enabled event survives read
    {2'd2, 2'd0, 8'h00, 3'b000, 8'hA0, 1'b0}  // R6 R7
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 rdata", rdata, 8'h00);
        chk("R1 irq", {7'd0, irq}, 8'h00);
        for (int i = 0; i < NV; i++) begin
          logic [23:0] v;
          v = VEC[i];
          wr_en = (v[23:22] == 2'd1);
          rd_en = (v[23:22] == 2'd2);
          addr = v[21:20];
          wdata = v[19:12];
          {evt_periodic, evt_alarm, evt_update} = v[11:9];
          @(negedge clk);
          wr_en = 0; rd_en = 0; {evt_periodic, evt_alarm, evt_update} = 3'b000;
          if (v[23:22] == 2'd2) chk($sformatf("vec%0d rdata", i), rdata, v[8:1]);
          chk($sformatf("vec%0d irq", i), {7'd0, irq}, {7'd0, v[0]});
        end
        // R1 mid-run reset clears enables and flags
        wr_en = 1; addr = 2'd1; wdata = 8'h70; evt_update = 1;
        @(negedge clk);
        wr_en = 0; evt_update = 0;
        chk("R5 pre-reset irq", {7'd0, irq}, 8'h01);
        rst_n = 0;
        @(negedge clk);
        rst_n = 1;
        chk("R1 irq after reset", {7'd0, irq}, 8'h00);
        rd_en = 1; addr = 2'd1;
        @(negedge clk);
        chk("R1 enables after reset", rdata, 8'h00);
        addr = 2'd0;
        @(negedge clk);
        rd_en = 0;
        chk("R1 flags after reset", rdata, 8'h00);
      end
      begin
        repeat (2000) @(negedge clk);
        fails++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule